// File: doc/BRIEF.md
# Bus Ownership Handshake Controller

This block sits between a bus master's access sequencer and the arbitration wires of a shared external bus. It decides when the master asks for the bus, when it takes ownership and starts driving bus-busy, and when it lets go. Four states are used: idle, requesting, active master and parked master. The parked state lets a master that has just finished its work keep the bus while the arbiter still grants it. A later access can then start without a new arbitration round.

A read-modify-write pair is never split. While the read half is in flight, the sequencer raises `rmw_read`. This masks the end-of-sequence flag, so the bus is not released between the read and the write. When the arbiter removes grant in the middle of a transfer, the controller keeps the bus until the current sequence reports its end. A configuration bit can keep the request line asserted while the controller is idle or parked.

The state is exported as a 2-bit code so that surrounding logic and the bench can see which arc was taken. All state changes happen on the rising clock edge. The outputs are decoded from the registered state.

Top module: `bus_own_ctrl`

## Requirements
- R1: A synchronous active-high `rst` puts the controller in idle (`own_state` = 0) at the next clock edge. In that state `acc_go` = 0 and `busy_drive` = 0.
- R2: `own_state` encodes idle = 0, requesting = 1, active = 2 and parked = 3. `acc_go` is 1 only in active. `busy_drive` is 1 in active and in parked, and 0 otherwise.
- R3: `bus_req_n` is active low. It is 0 in requesting and in active. In idle and in parked it equals the inverse of `req_hold`, so `req_hold` = 1 keeps the request asserted.
- R4: In idle with `acc_req` = 0 the state stays idle. With `acc_req` = 1, `bus_grant` = 1 and `bus_busy_in` = 0, the next state is active. With `acc_req` = 1 and any other grant/busy combination, the next state is requesting.
- R5: In requesting the controller moves to active once `bus_grant` = 1 and `bus_busy_in` = 0. Otherwise it stays in requesting, whatever `acc_req` does. It never goes directly to idle or to parked.
- R6: Active is left only when the effective end of sequence is 1 (`end_seq` = 1 and `rmw_read` = 0). If `bus_grant` = 0 the next state is idle. If `bus_grant` = 1 and `acc_req` = 0 the next state is parked. Otherwise the state stays active.
- R7: While `rmw_read` = 1, end of sequence is treated as 0, so an active controller stays active regardless of grant.
- R8: In parked, `bus_grant` = 0 leads to idle. `bus_grant` = 1 together with `acc_req` = 1 leads to active. Otherwise the state stays parked. Parked never leads to requesting.
- R9: Under random request, grant, busy, end-of-sequence and read-modify-write stimulus, the arcs requesting→idle, requesting→parked and parked→requesting are never taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| acc_req | input | 1 | An external access is pending |
| bus_grant | input | 1 | Arbiter grant, 1 = granted |
| bus_busy_in | input | 1 | Another master holds the bus, 1 = busy |
| end_seq | input | 1 | Current access sequence ends in this cycle |
| rmw_read | input | 1 | Read half of a read-modify-write in progress |
| req_hold | input | 1 | Keep request asserted while idle or parked |
| bus_req_n | output | 1 | Bus request, active low |
| busy_drive | output | 1 | Drive bus-busy, 1 = bus owned |
| acc_go | output | 1 | Access may proceed on the bus |
| own_state | output | 2 | Current state code |

## Verification
The embedded assertions check on every clock that the forbidden arcs out of requesting and parked never occur. On every clock they also check that active is held whenever end of sequence is missing or masked by the read half of a read-modify-write, and that idle stays idle without a request. The request-line level that depends on the hold bit, the choice between a direct idle→active entry and a detour through requesting, and the parking decision are shown only by the bench's vector table and its reference model. The same applies to reset taking effect from the active state.

// File: rtl/bus_own_pkg.sv
package bus_own_pkg;

  localparam int OWN_STATE_W = 2;

  typedef enum logic [OWN_STATE_W-1:0] {
    OWN_IDLE   = 2'd0,
    OWN_REQ    = 2'd1,
    OWN_ACTIVE = 2'd2,
    OWN_PARK   = 2'd3
  } own_state_e;

  // Next-state decision. usable = grant present and bus free; eos = masked end of sequence.
  function automatic own_state_e own_next(own_state_e cur, logic want, logic gnt,
                                          logic usable, logic eos);
    own_state_e nxt;
    nxt = cur;
    unique case (cur)
      OWN_IDLE: begin
        if (want) nxt = usable ? OWN_ACTIVE : OWN_REQ;
      end
      OWN_REQ: begin
        if (usable) nxt = OWN_ACTIVE;
      end
      OWN_ACTIVE: begin
        if (eos) begin
          if (!gnt)      nxt = OWN_IDLE;
          else if (!want) nxt = OWN_PARK;
        end
      end
      OWN_PARK: begin
        if (!gnt)      nxt = OWN_IDLE;
        else if (want) nxt = OWN_ACTIVE;
      end
      default: nxt = OWN_IDLE;
    endcase
    return nxt;
  endfunction

  // Request line level, active low.
  function automatic logic own_req_level_n(own_state_e s, logic hold);
    return (s == OWN_REQ || s == OWN_ACTIVE) ? 1'b0 : ~hold;
  endfunction

  function automatic logic own_holds_bus(own_state_e s);
    return (s == OWN_ACTIVE || s == OWN_PARK);
  endfunction

endpackage

// File: rtl/bus_own_qual.sv
module bus_own_qual (
  input  logic bus_grant,
  input  logic bus_busy_in,
  input  logic end_seq,
  input  logic rmw_read,
  output logic grant_usable,
  output logic eos_eff
);
  // Ownership may be taken only with grant present and no other master busy.
  assign grant_usable = bus_grant & ~bus_busy_in;
  // The read half of a read-modify-write masks end of sequence.
  assign eos_eff = end_seq & ~rmw_read;
endmodule

// File: rtl/bus_own_fsm.sv
module bus_own_fsm
  import bus_own_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       acc_req,
  input  logic       bus_grant,
  input  logic       rmw_read,
  input  logic       grant_usable,
  input  logic       eos_eff,
  output own_state_e state_q
);
  own_state_e state_d;

  always_comb state_d = own_next(state_q, acc_req, bus_grant, grant_usable, eos_eff);

  always_ff @(posedge clk) begin
    if (rst) state_q <= OWN_IDLE;
    else     state_q <= state_d;
  end

  // R4: idle stays idle without a request
  a_r4_idle_waits: assert property (@(posedge clk) disable iff (rst)
    (state_q == OWN_IDLE && !acc_req) |=> state_q == OWN_IDLE);

  // R5: requesting never falls to idle or parked
  a_r5_req_no_drop: assert property (@(posedge clk) disable iff (rst)
    (state_q == OWN_REQ) |=> (state_q != OWN_IDLE && state_q != OWN_PARK));

  // R6: active is held when end of sequence is absent
  a_r6_active_holds: assert property (@(posedge clk) disable iff (rst)
    (state_q == OWN_ACTIVE && !eos_eff) |=> state_q == OWN_ACTIVE);

  // R7: read half of read-modify-write keeps the bus
  a_r7_rmw_keeps: assert property (@(posedge clk) disable iff (rst)
    (state_q == OWN_ACTIVE && rmw_read) |=> state_q == OWN_ACTIVE);

  // R8: parked never re-enters requesting
  a_r8_park_no_req: assert property (@(posedge clk) disable iff (rst)
    (state_q == OWN_PARK) |=> state_q != OWN_REQ);

endmodule

// File: rtl/bus_own_out.sv
module bus_own_out
  import bus_own_pkg::*;
(
  input  own_state_e state_q,
  input  logic       req_hold,
  output logic       bus_req_n,
  output logic       busy_drive,
  output logic       acc_go
);
  always_comb begin
    bus_req_n  = own_req_level_n(state_q, req_hold);
    busy_drive = own_holds_bus(state_q);
    acc_go     = (state_q == OWN_ACTIVE);
  end
endmodule

// File: rtl/bus_own_ctrl.sv
module bus_own_ctrl
  import bus_own_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   acc_req,
  input  logic                   bus_grant,
  input  logic                   bus_busy_in,
  input  logic                   end_seq,
  input  logic                   rmw_read,
  input  logic                   req_hold,
  output logic                   bus_req_n,
  output logic                   busy_drive,
  output logic                   acc_go,
  output logic [OWN_STATE_W-1:0] own_state
);
  logic       grant_usable;
  logic       eos_eff;
  own_state_e state_q;

  bus_own_qual u_qual (
    .bus_grant   (bus_grant),
    .bus_busy_in (bus_busy_in),
    .end_seq     (end_seq),
    .rmw_read    (rmw_read),
    .grant_usable(grant_usable),
    .eos_eff     (eos_eff)
  );

  bus_own_fsm u_fsm (
    .clk         (clk),
    .rst         (rst),
    .acc_req     (acc_req),
    .bus_grant   (bus_grant),
    .rmw_read    (rmw_read),
    .grant_usable(grant_usable),
    .eos_eff     (eos_eff),
    .state_q     (state_q)
  );

  bus_own_out u_out (
    .state_q   (state_q),
    .req_hold  (req_hold),
    .bus_req_n (bus_req_n),
    .busy_drive(busy_drive),
    .acc_go    (acc_go)
  );

  assign own_state = state_q;
endmodule

// File: tb/bus_own_ctrl_test.sv
module bus_own_ctrl_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic acc_req = 0, bus_grant = 0, bus_busy_in = 0, end_seq = 0, rmw_read = 0, req_hold = 0;
  logic bus_req_n, busy_drive, acc_go;
  logic [1:0] own_state;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  bus_own_ctrl uut (
    .clk(clk), .rst(rst), .acc_req(acc_req), .bus_grant(bus_grant),
    .bus_busy_in(bus_busy_in), .end_seq(end_seq), .rmw_read(rmw_read),
    .req_hold(req_hold), .bus_req_n(bus_req_n), .busy_drive(busy_drive),
    .acc_go(acc_go), .own_state(own_state)
  );

  // {req,gnt,busy,eos,rmw,hold} _ expected state _ req_n _ go _ busy_drive
  localparam int NVEC = 17;
  localparam logic [10:0] VEC [NVEC] = '{
    11'b000000_00_1_0_0, // R4 idle stays, R3 hold 0
    11'b000001_00_0_0_0, // R3 hold keeps request low
    11'b100000_01_0_0_0, // R4 no grant -> requesting
    11'b111000_01_0_0_0, // R5 busy blocks
    11'b000000_01_0_0_0, // R5 request dropped, still requesting
    11'b110000_10_0_1_1, // R5 -> active, R2
    11'b000000_10_0_1_1, // R6 grant gone, no eos
    11'b000110_10_0_1_1, // R7 rmw masks eos
    11'b010100_11_1_0_1, // R6 -> parked
    11'b010001_11_0_0_1, // R3 parked with hold
    11'b110000_10_0_1_1, // R8 parked -> active
    11'b110100_10_0_1_1, // R6 eos with request pending
    11'b000100_00_1_0_0, // R6 grant gone + eos -> idle
    11'b110000_10_0_1_1, // R4 direct idle -> active
    11'b010100_11_1_0_1, // R6 -> parked
    11'b100000_00_1_0_0, // R8 grant gone -> idle
    11'b111000_01_0_0_0  // R4 busy -> requesting
  };

  task automatic check(string tag, logic [4:0] act, logic [4:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got st=%0d req_n=%b go=%b bsy=%b expected st=%0d req_n=%b go=%b bsy=%b",
               tag, act[4:3], act[2], act[1], act[0], exp[4:3], exp[2], exp[1], exp[0]);
    end
  endtask

  function automatic logic [1:0] model_next(logic [1:0] s, logic r, logic g, logic b,
                                            logic e, logic m);
    case (s)
      2'd0: return !r ? 2'd0 : ((g && !b) ? 2'd2 : 2'd1);
      2'd1: return (g && !b) ? 2'd2 : 2'd1;
      2'd2: begin
        if (!(e && !m)) return 2'd2;
        if (!g) return 2'd0;
        return r ? 2'd2 : 2'd3;
      end
      default: return !g ? 2'd0 : (r ? 2'd2 : 2'd3);
    endcase
  endfunction

  function automatic logic [4:0] model_out(logic [1:0] s, logic h);
    logic rn;
    rn = (s == 2'd1 || s == 2'd2) ? 1'b0 : ~h;
    return {s, rn, s == 2'd2, s[1]};
  endfunction

  initial begin
    #(20 * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [1:0] m;
    logic [1:0] prev;
    int illegal;
    @(negedge clk); @(negedge clk);
    check("R1 reset state", {own_state, bus_req_n, acc_go, busy_drive}, 5'b00_1_0_0);
    rst = 0;

    for (int i = 0; i < NVEC; i++) begin
      {acc_req, bus_grant, bus_busy_in, end_seq, rmw_read, req_hold} = VEC[i][10:5];
      @(posedge clk); @(negedge clk);
      check($sformatf("R2 R3 table vector %0d", i),
            {own_state, bus_req_n, acc_go, busy_drive}, VEC[i][4:0]);
    end

    // R1: reset from active
    {acc_req, bus_grant, bus_busy_in, end_seq, rmw_read, req_hold} = 6'b110000;
    @(posedge clk); @(negedge clk);
    check("R1 pre-reset active", {own_state, bus_req_n, acc_go, busy_drive}, 5'b10_0_1_1);
    rst = 1;
    @(posedge clk); @(negedge clk);
    check("R1 reset from active", {own_state, bus_req_n, acc_go, busy_drive}, 5'b00_1_0_0);
    rst = 0;

    // R9: random stimulus against an independent model
    m = 2'd0;
    illegal = 0;
    for (int k = 0; k < 3000; k++) begin
      acc_req     = ($urandom % 2) == 0;
      bus_grant   = ($urandom % 4) != 0;
      bus_busy_in = ($urandom % 4) == 0;
      end_seq     = ($urandom % 3) == 0;
      rmw_read    = ($urandom % 4) == 0;
      req_hold    = ($urandom % 2) == 0;
      prev = own_state;
      m = model_next(m, acc_req, bus_grant, bus_busy_in, end_seq, rmw_read);
      @(posedge clk); @(negedge clk);
      if ((prev == 2'd1 && (own_state == 2'd0 || own_state == 2'd3)) ||
          (prev == 2'd3 && own_state == 2'd1)) illegal++;
      check("R9 random vs model", {own_state, bus_req_n, acc_go, busy_drive},
            model_out(m, req_hold));
    end
    checks++;
    if (illegal != 0) begin
      errors++;
      $display("FAIL R9 illegal arcs: got %0d expected 0", illegal);
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule